// File: doc/BRIEF.md
# Unaligned Memory Access Splitter

This block sits between a load/store unit and a 64-bit memory bus that has per-byte enables. It accepts one access at a time. Each access carries a byte address, an operand size of 1, 2, 4 or 8 bytes, a read/write flag and write data. The block decides whether the operand fits in one bus cycle or has to be split into two.

The split rule depends on the operand size:

- A byte never splits.
- A 2-byte or 4-byte operand splits only when it runs over a 4-byte chunk boundary. A 2-byte operand at an odd address that stays inside its chunk still takes one cycle.
- An 8-byte operand splits whenever it is not 8-byte aligned.

For each bus cycle the block presents a line-aligned address, a byte-enable mask and write data rotated onto the matching lanes. For reads, the returned lanes of both pieces are merged into one right-justified little-endian result.

Both the request side and the bus side use valid/ready handshakes. Only one access is in flight at a time. The response is a single-cycle pulse, and it carries a flag that says whether the access was split.

Top module: `mem_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_valid` is 0 and `resp_valid` is 0.
- R2: A 1-byte access always takes exactly one bus cycle. Its enable mask has only bit `addr[2:0]` set.
- R3: A 2-byte or 4-byte access with `(addr mod 4) + size > 4` takes two bus cycles and reports `resp_split`=1.
- R4: A 2-byte or 4-byte access that stays inside one 4-byte chunk takes one bus cycle and reports `resp_split`=0. This includes an odd-addressed 2-byte access.
- R5: An 8-byte access takes two bus cycles exactly when `addr[2:0]` is not 0. Otherwise it takes one.
- R6: Every bus cycle uses an address whose low 3 bits are zero. In a split access the lower-addressed bytes go first.
  - The second piece uses the next line (+8) when the operand crosses an 8-byte boundary.
  - It uses the same line when the operand only crosses a 4-byte boundary inside it.
- R7: Operand byte k is driven on lane `(addr + k) mod 8`, that is bits `[8*lane+7 : 8*lane]` of `bus_wdata`. Its enable bit is set in whichever cycle carries that byte.
- R8: A read returns operand byte k, taken from address `addr + k`, in `resp_rdata[8k+7:8k]`. All bits above the operand size are 0.
- R9: `req_ready` is 0 from the cycle after acceptance until the last bus handshake. While `bus_valid` is 1 and `bus_ready` is 0, the bus address, enables and write data stay unchanged.
- R10: `resp_valid` is high for exactly one cycle, the cycle after the final bus handshake. `req_ready` returns to 1 in that same cycle.
- R11: `bus_write` equals the request's write flag in every bus cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store operand, right-justified |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load result, right-justified, zero-extended (0 for stores) |
| resp_split | output | 1 | Access used two bus cycles |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus accepts the cycle; read data is valid with it |
| bus_addr | output | ADDR_W | Line-aligned bus address |
| bus_write | output | 1 | Bus cycle direction |
| bus_be | output | DATA_W/8 | Byte-lane enables |
| bus_wdata | output | DATA_W | Lane-rotated write data |
| bus_rdata | input | DATA_W | Read data lanes |

## Verification
A request accepted at a clock edge shows its first bus piece on the next cycle. Each piece completes at an edge where `bus_valid` and `bus_ready` are both high, and the response pulse appears one cycle after the last such edge. The bench drives inputs and samples outputs on the falling edge. It logs a handshake at the falling edge just before the rising edge that completes it, reads the response once `resp_valid` is seen, and checks on the next falling edge that the pulse has dropped. Stall windows are checked at every falling edge for unchanged bus fields.

// File: rtl/mem_split_pkg.sv
package mem_split_pkg;
  typedef enum logic [1:0] {
    SZ_1 = 2'd0,
    SZ_2 = 2'd1,
    SZ_4 = 2'd2,
    SZ_8 = 2'd3
  } op_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } split_state_e;
endpackage

// File: rtl/split_decode.sv
// Works out lane masks and rotated data for the two possible pieces of an access.
module split_decode
  import mem_split_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int NARROW = 4
) (
  input  logic [$clog2(LANES)-1:0] off,
  input  op_size_e                 size,
  input  logic [8*LANES-1:0]       wdata,
  output logic                     split,
  output logic                     upper,
  output logic [LANES-1:0]         be_lo,
  output logic [LANES-1:0]         be_hi,
  output logic [8*LANES-1:0]       wd_lo,
  output logic [8*LANES-1:0]       wd_hi
);
  localparam int DW = 8 * LANES;

  logic [2*LANES-1:0] span;
  logic [2*LANES-1:0] below;
  logic [2*LANES-1:0] lo_part;
  logic [2*LANES-1:0] hi_part;
  logic [2*DW-1:0]    wide;
  int                 nbytes;
  int                 edge_pos;

  always_comb begin
    nbytes = 1 << int'(size);
    if (size == SZ_8) edge_pos = LANES;
    else              edge_pos = (int'(off) / NARROW + 1) * NARROW;
    for (int i = 0; i < 2 * LANES; i++) begin
      span[i]  = (i >= int'(off)) && (i < int'(off) + nbytes);
      below[i] = (i < edge_pos);
    end
    lo_part = span & below;
    hi_part = span & ~below;
    split   = |hi_part;
    upper   = (edge_pos == LANES);
    be_lo   = lo_part[LANES-1:0];
    be_hi   = upper ? hi_part[2*LANES-1:LANES] : hi_part[LANES-1:0];
    wide    = {{DW{1'b0}}, wdata} << (8 * int'(off));
    wd_lo   = wide[DW-1:0];
    wd_hi   = upper ? wide[2*DW-1:DW] : wide[DW-1:0];
  end
endmodule

// File: rtl/lane_merge.sv
// Rebuilds a right-justified load result from one or two returned lines.
module lane_merge
  import mem_split_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0]       first_data,
  input  logic [8*LANES-1:0]       last_data,
  input  logic [LANES-1:0]         be_lo,
  input  logic [LANES-1:0]         be_hi,
  input  logic                     split,
  input  logic                     upper,
  input  logic [$clog2(LANES)-1:0] off,
  input  op_size_e                 size,
  output logic [8*LANES-1:0]       result
);
  localparam int DW = 8 * LANES;

  logic [DW-1:0]   m_lo, m_hi, keep;
  logic [DW-1:0]   lo, hi;
  logic [2*DW-1:0] shifted;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      m_lo[8*i +: 8] = {8{be_lo[i]}};
      m_hi[8*i +: 8] = {8{be_hi[i]}};
      keep[8*i +: 8] = {8{i < (1 << int'(size))}};
    end
    if (split) begin
      lo = (first_data & m_lo) | (upper ? '0 : (last_data & m_hi));
      hi = upper ? (last_data & m_hi) : '0;
    end else begin
      lo = last_data & m_lo;
      hi = '0;
    end
    shifted = {hi, lo} >> (8 * int'(off));
    result  = shifted[DW-1:0] & keep;
  end
endmodule

// File: rtl/mem_split_unit.sv
module mem_split_unit
  import mem_split_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 64,
  parameter int NARROW_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                resp_valid,
  output logic [DATA_W-1:0]   resp_rdata,
  output logic                resp_split,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  split_state_e     state;
  logic [OFF_W-1:0] off_q;
  op_size_e         size_q;
  logic             split_q, upper_q;
  logic [LANES-1:0] be_lo_q, be_hi_q;
  logic [DATA_W-1:0] wd_hi_q, first_q;

  logic              dec_split, dec_upper;
  logic [LANES-1:0]  dec_be_lo, dec_be_hi;
  logic [DATA_W-1:0] dec_wd_lo, dec_wd_hi;
  logic [DATA_W-1:0] merged;
  logic              handshake;

  split_decode #(.LANES(LANES), .NARROW(NARROW_BYTES)) u_decode (
    .off   (req_addr[OFF_W-1:0]),
    .size  (op_size_e'(req_size)),
    .wdata (req_wdata),
    .split (dec_split),
    .upper (dec_upper),
    .be_lo (dec_be_lo),
    .be_hi (dec_be_hi),
    .wd_lo (dec_wd_lo),
    .wd_hi (dec_wd_hi)
  );

  lane_merge #(.LANES(LANES)) u_merge (
    .first_data (first_q),
    .last_data  (bus_rdata),
    .be_lo      (be_lo_q),
    .be_hi      (be_hi_q),
    .split      (split_q),
    .upper      (upper_q),
    .off        (off_q),
    .size       (size_q),
    .result     (merged)
  );

  assign req_ready = (state == ST_IDLE);
  assign handshake = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      off_q      <= '0;
      size_q     <= SZ_1;
      split_q    <= 1'b0;
      upper_q    <= 1'b0;
      be_lo_q    <= '0;
      be_hi_q    <= '0;
      wd_hi_q    <= '0;
      first_q    <= '0;
      bus_valid  <= 1'b0;
      bus_addr   <= '0;
      bus_write  <= 1'b0;
      bus_be     <= '0;
      bus_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_split <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            off_q     <= req_addr[OFF_W-1:0];
            size_q    <= op_size_e'(req_size);
            split_q   <= dec_split;
            upper_q   <= dec_upper;
            be_lo_q   <= dec_be_lo;
            be_hi_q   <= dec_be_hi;
            wd_hi_q   <= dec_wd_hi;
            bus_valid <= 1'b1;
            bus_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            bus_write <= req_write;
            bus_be    <= dec_be_lo;
            bus_wdata <= dec_wd_lo;
            state     <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (handshake) begin
            first_q <= bus_rdata;
            if (split_q) begin
              bus_be    <= be_hi_q;
              bus_wdata <= wd_hi_q;
              if (upper_q) bus_addr <= bus_addr + ADDR_W'(LANES);
              state <= ST_HIGH;
            end else begin
              bus_valid  <= 1'b0;
              resp_valid <= 1'b1;
              resp_rdata <= bus_write ? '0 : merged;
              resp_split <= 1'b0;
              state      <= ST_IDLE;
            end
          end
        end
        ST_HIGH: begin
          if (handshake) begin
            bus_valid  <= 1'b0;
            resp_valid <= 1'b1;
            resp_rdata <= bus_write ? '0 : merged;
            resp_split <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_split_checks.sv
module mem_split_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                resp_valid,
  input logic                bus_valid,
  input logic                bus_ready,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !req_ready);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_resp_after_hs_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(resp_valid) |-> $past(bus_valid && bus_ready));

  assert_resp_ready_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

  assert_line_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

  assert_accept_issues_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (bus_valid && (bus_be != '0)));
endmodule

bind mem_split_unit mem_split_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata)
);

// File: tb/mem_split_unit_test.sv
module mem_split_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        resp_valid;
  logic [63:0] resp_rdata;
  logic        resp_split;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [7:0]  bus_be;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [64];
  int          log_n = 0;
  int          hold_left = 0;
  logic [31:0] log_addr [4];
  logic [7:0]  log_be [4];
  logic [63:0] log_wd [4];
  logic        log_wr [4];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic [7:0]  prev_be;
  logic [63:0] prev_wd;

  always #2.5 clk = ~clk;

  mem_split_unit uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_split(resp_split),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Each entry: {addr[7:0], size code[1:0], expected split}
  localparam logic [10:0] VEC [16] = '{
    {8'd0,  2'd0, 1'b0}, {8'd5,  2'd0, 1'b0}, {8'd7,  2'd0, 1'b0},
    {8'd1,  2'd1, 1'b0}, {8'd3,  2'd1, 1'b1}, {8'd7,  2'd1, 1'b1},
    {8'd13, 2'd1, 1'b0}, {8'd2,  2'd2, 1'b1}, {8'd4,  2'd2, 1'b0},
    {8'd6,  2'd2, 1'b1}, {8'd14, 2'd2, 1'b1}, {8'd11, 2'd2, 1'b1},
    {8'd0,  2'd3, 1'b0}, {8'd4,  2'd3, 1'b1}, {8'd1,  2'd3, 1'b1},
    {8'd8,  2'd3, 1'b0}
  };

  always_comb begin
    for (int l = 0; l < 8; l++) bus_rdata[8*l +: 8] = mem[{bus_addr[5:3], 3'(l)}];
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bus model: stalls, logging, stability checks, reference memory writes.
  always @(negedge clk) begin
    if (prev_stall) begin
      check("R9 stall addr", 64'(bus_addr), 64'(prev_addr));
      check("R9 stall be", 64'(bus_be), 64'(prev_be));
      check("R9 stall wdata", bus_wdata, prev_wd);
      check("R9 stall ready", 64'(req_ready), 64'd0);
    end
    if (bus_valid && hold_left > 0) begin
      bus_ready = 1'b0;
      hold_left--;
    end else begin
      bus_ready = 1'b1;
    end
    prev_stall = bus_valid && !bus_ready;
    prev_addr  = bus_addr;
    prev_be    = bus_be;
    prev_wd    = bus_wdata;
    if (bus_valid && bus_ready) begin
      if (log_n < 4) begin
        log_addr[log_n] = bus_addr;
        log_be[log_n]   = bus_be;
        log_wd[log_n]   = bus_wdata;
        log_wr[log_n]   = bus_write;
      end
      log_n++;
      if (bus_write)
        for (int l = 0; l < 8; l++)
          if (bus_be[l]) mem[{bus_addr[5:3], 3'(l)}] = bus_wdata[8*l +: 8];
    end
  end

  function automatic logic [63:0] ref_read(input logic [7:0] a, input logic [1:0] sz);
    logic [63:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = mem[6'(a + 8'(k))];
    return v;
  endfunction

  task automatic run_access(input logic [7:0] a, input logic [1:0] sz, input logic wr,
                            input logic [63:0] wd, input int hold,
                            output logic [63:0] rd, output logic sp, output int nb);
    int guard = 0;
    while (!req_ready) @(negedge clk);
    log_n     = 0;
    hold_left = hold;
    req_valid = 1'b1;
    req_addr  = 32'(a);
    req_size  = sz;
    req_write = wr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", 64'(req_ready), 64'd0);
    while (!resp_valid && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    rd = resp_rdata;
    sp = resp_split;
    nb = log_n;
    check("R10 ready with response", 64'(req_ready), 64'd1);
    @(negedge clk);
    check("R10 single-cycle pulse", 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd, exp;
    logic        sp;
    int          nb;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 bus_valid", 64'(bus_valid), 64'd0);
    check("R1 resp_valid", 64'(resp_valid), 64'd0);

    // Table walk: reads covering R2, R3, R4, R5, R8
    for (int v = 0; v < 16; v++) begin
      exp = ref_read(VEC[v][10:3], VEC[v][2:1]);
      run_access(VEC[v][10:3], VEC[v][2:1], 1'b0, '0, v % 3, rd, sp, nb);
      check("R8 read data", rd, exp);
      check("R3/R4/R5 split flag", 64'(sp), 64'(VEC[v][0]));
      check("R3/R4/R5 bus cycles", 64'(nb), VEC[v][0] ? 64'd2 : 64'd1);
      check("R11 read direction", 64'(log_wr[0]), 64'd0);
    end

    // R3 R6 R7 R11: dword at 22 crosses an 8-byte line
    run_access(8'd22, 2'd2, 1'b1, 64'hA1B2C3D4, 0, rd, sp, nb);
    check("R3 write split", 64'(sp), 64'd1);
    check("R6 two cycles", 64'(nb), 64'd2);
    check("R6 first addr", 64'(log_addr[0]), 64'd16);
    check("R6 first be", 64'(log_be[0]), 64'hC0);
    check("R7 first lanes", 64'(log_wd[0][63:48]), 64'hC3D4);
    check("R6 second addr", 64'(log_addr[1]), 64'd24);
    check("R6 second be", 64'(log_be[1]), 64'h03);
    check("R7 second lanes", 64'(log_wd[1][15:0]), 64'hA1B2);
    check("R11 write flag", 64'({log_wr[0], log_wr[1]}), 64'd3);
    run_access(8'd22, 2'd2, 1'b0, '0, 2, rd, sp, nb);
    check("R8 dword readback", rd, 64'hA1B2C3D4);

    // R6 R7: word at 3 crosses only a 4-byte boundary, same line twice
    run_access(8'd3, 2'd1, 1'b1, 64'hBEEF, 1, rd, sp, nb);
    check("R6 same-line count", 64'(nb), 64'd2);
    check("R6 same-line addr0", 64'(log_addr[0]), 64'd0);
    check("R6 same-line addr1", 64'(log_addr[1]), 64'd0);
    check("R6 same-line be0", 64'(log_be[0]), 64'h08);
    check("R6 same-line be1", 64'(log_be[1]), 64'h10);
    check("R7 low lane", 64'(log_wd[0][31:24]), 64'hEF);
    check("R7 high lane", 64'(log_wd[1][39:32]), 64'hBE);
    run_access(8'd3, 2'd1, 1'b0, '0, 0, rd, sp, nb);
    check("R8 word readback", rd, 64'hBEEF);

    // R5 R7: quadword at offset 5
    run_access(8'd37, 2'd3, 1'b1, 64'h0102030405060708, 0, rd, sp, nb);
    check("R5 quad split", 64'(sp), 64'd1);
    check("R5 quad be0", 64'(log_be[0]), 64'hE0);
    check("R7 quad lanes0", 64'(log_wd[0][63:40]), 64'h060708);
    check("R5 quad addr1", 64'(log_addr[1]), 64'd40);
    check("R5 quad be1", 64'(log_be[1]), 64'h1F);
    check("R7 quad lanes1", 64'(log_wd[1][39:0]), 64'h0102030405);
    run_access(8'd37, 2'd3, 1'b0, '0, 3, rd, sp, nb);
    check("R8 quad readback", rd, 64'h0102030405060708);

    // R2: single byte store
    run_access(8'd45, 2'd0, 1'b1, 64'h5A, 0, rd, sp, nb);
    check("R2 byte cycles", 64'(nb), 64'd1);
    check("R2 byte addr", 64'(log_addr[0]), 64'd40);
    check("R2 byte be", 64'(log_be[0]), 64'h20);
    check("R7 byte lane", 64'(log_wd[0][47:40]), 64'h5A);
    run_access(8'd45, 2'd0, 1'b0, '0, 4, rd, sp, nb);
    check("R8 byte zero-extend", rd, 64'h5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule